// File: doc/BRIEF.md
# Two-Wire Register Slave with Latched Interrupt

This block is the control port of a mixed-signal peripheral. It is a slave on a two-wire serial bus (I2C-compatible) that answers to one fixed 7-bit device address. It holds a small register file that the host reads and writes through an auto-incrementing byte pointer. The first two registers are status words. Event pulses from the surrounding logic set their bits, and a host read of a status register clears it. A third register holds per-bit enables that decide which bits of the first status word may pull the interrupt line low.

SCL and SDA arrive already synchronized to the system clock. The block drives the bus through a pull-down enable, so the line is low when `sda_pull` is 1. It signals the interrupt through an open-drain pull-down, so the line is low when `irq_pull` is 1. The contents of every register are exposed in parallel, so the analog and mixing logic can use them directly. Clock stretching and multi-master arbitration are not provided.

Top module: `i2cs_regslave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 0010000, so the byte is 0x20 for a write and 0x21 for a read (bit 0 is 1 for a read). For any other address it leaves SDA released in the acknowledge slot.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one. Every byte is acknowledged.
- R3: A read that begins after a START from an idle bus starts at register 0x00. A read that follows a pointer write through a repeated START starts at that pointer.
- R4: During a read, the pointer advances after every byte sent. The slave keeps sending while the master acknowledges. After the master's NACK it stops driving SDA.
- R5: Bit i of `evt_in[7:0]` sets bit i of register 0x00, and bit i of `evt_in[15:8]` sets bit i of register 0x01. A host read of either status register clears it.
- R6: An event that arrives in the same cycle as the read-clear of its status register leaves its bit set afterwards.
- R7: `irq_pull` rises when register 0x00 has a set bit whose enable bit at the same position in register 0x02 is 1. Flags with a clear enable bit do not raise it.
- R8: Once `irq_pull` is high it stays high until register 0x00 is read. Reading register 0x01 or repeating events does not release it.
- R9: A STOP ends a transfer at any point, including mid-byte, and a partial byte is not stored. A STOP edge seen during the same SCL high period as the START is ignored.
- R10: Writes to registers 0x00, 0x01 and to pointers above 0x1C are acknowledged and have no effect. Reads above 0x1C return 0x00.
- R11: After reset, all registers are 0x00, SDA is released and `irq_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized serial clock |
| sda_in | input | 1 | Synchronized serial data line level |
| evt_in | input | NUM_STATUS*8 | Event pulses; byte k sets status register k |
| sda_pull | output | 1 | Pull SDA low when 1 |
| irq_pull | output | 1 | Pull the interrupt line low when 1 |
| reg_bank | output | NUM_REGS*8 | Register k at bits [8k+7:8k] |

## Verification
A wrong pointer shows up within one byte. The first data byte read back or written lands at the wrong register, and this is visible at `reg_bank` or on SDA in the next read. A corrupted transfer state shows up in the following acknowledge slot as a missing or extra pull-down. A wrong interrupt latch or a wrong clear-on-read shows up at `irq_pull` within two clock cycles of the event pulse or the status read, and in the value the next status read returns.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 8;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_RX_ACK,
        LS_TX,
        LS_TX_ACK
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2cs_bus_edge.sv
module i2cs_bus_edge
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;
    logic start_hold;
    logic start_raw;
    logic stop_raw;

    always_comb begin
        start_raw = scl_in & scl_q & sda_q & ~sda_in;
        stop_raw  = scl_in & scl_q & ~sda_q & sda_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            start_hold <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_raw)
                start_hold <= 1'b1;
            else if (!scl_in)
                start_hold <= 1'b0;
        end
    end

    always_comb begin
        evt.start    = start_raw;
        evt.stop     = stop_raw & ~start_hold;
        evt.scl_rise = scl_in & ~scl_q;
        evt.scl_fall = ~scl_in & scl_q;
        evt.sda      = sda_in;
    end

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output reg_wr_t           wr_req,
    output logic              rd_pulse,
    output logic [PTR_W-1:0]  rd_addr
);

    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);
    localparam logic [3:0] BITS_LAST = 4'(BYTE_W - 1);

    link_state_e       st;
    rx_phase_e         ph;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              is_read;
    logic              ptr_armed;
    logic              busy;
    logic              use_preset;
    logic              nack;
    logic              oe_q;

    logic byte_done;
    logic load_tx;

    always_comb begin
        byte_done = evt.scl_fall && (st == LS_RX) && (cnt == BITS_FULL);
        load_tx   = evt.scl_fall &&
                    (((st == LS_RX_ACK) && is_read) || ((st == LS_TX_ACK) && !nack));
        rd_pulse  = load_tx;
        rd_addr   = ptr;
        wr_req.en   = byte_done && (ph == PH_DATA);
        wr_req.addr = ptr;
        wr_req.data = shreg;
        sda_oe    = oe_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= LS_IDLE;
            ph         <= PH_ADDR;
            cnt        <= '0;
            shreg      <= '0;
            ptr        <= '0;
            is_read    <= 1'b0;
            ptr_armed  <= 1'b0;
            busy       <= 1'b0;
            use_preset <= 1'b0;
            nack       <= 1'b0;
            oe_q       <= 1'b0;
        end else if (evt.stop) begin
            st        <= LS_IDLE;
            busy      <= 1'b0;
            ptr_armed <= 1'b0;
            oe_q      <= 1'b0;
        end else if (evt.start) begin
            st         <= LS_RX;
            ph         <= PH_ADDR;
            cnt        <= '0;
            oe_q       <= 1'b0;
            busy       <= 1'b1;
            use_preset <= busy && ptr_armed;
        end else begin
            unique case (st)
                LS_RX: begin
                    if (evt.scl_rise && (cnt != BITS_FULL)) begin
                        shreg <= {shreg[BYTE_W-2:0], evt.sda};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        cnt <= '0;
                        unique case (ph)
                            PH_ADDR: begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    is_read <= shreg[0];
                                    oe_q    <= 1'b1;
                                    st      <= LS_RX_ACK;
                                    if (shreg[0]) begin
                                        if (!use_preset)
                                            ptr <= '0;
                                    end else begin
                                        ph <= PH_PTR;
                                    end
                                end else begin
                                    st <= LS_IDLE;
                                end
                            end
                            PH_PTR: begin
                                ptr       <= shreg;
                                ptr_armed <= 1'b1;
                                ph        <= PH_DATA;
                                oe_q      <= 1'b1;
                                st        <= LS_RX_ACK;
                            end
                            default: begin
                                ptr  <= ptr + 1'b1;
                                oe_q <= 1'b1;
                                st   <= LS_RX_ACK;
                            end
                        endcase
                    end
                end
                LS_RX_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                            oe_q  <= ~rd_data[BYTE_W-1];
                            st    <= LS_TX;
                        end else begin
                            oe_q <= 1'b0;
                            st   <= LS_RX;
                        end
                    end
                end
                LS_TX: begin
                    if (evt.scl_fall) begin
                        if (cnt == BITS_LAST) begin
                            oe_q <= 1'b0;
                            st   <= LS_TX_ACK;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~shreg[BYTE_W-2];
                            cnt   <= cnt + 4'd1;
                        end
                    end
                end
                LS_TX_ACK: begin
                    if (evt.scl_rise)
                        nack <= evt.sda;
                    if (evt.scl_fall) begin
                        if (!nack) begin
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                            oe_q  <= ~rd_data[BYTE_W-1];
                            cnt   <= '0;
                            st    <= LS_TX;
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 29,
    parameter int unsigned NUM_STATUS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  reg_wr_t                      wr_req,
    input  logic                         rd_pulse,
    input  logic [PTR_W-1:0]             rd_addr,
    input  logic [NUM_STATUS*BYTE_W-1:0] evt_in,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         irq_pull,
    output logic [NUM_REGS*BYTE_W-1:0]   reg_bank
);

    localparam int unsigned IEN_IDX = NUM_STATUS;

    logic [BYTE_W-1:0] bank [NUM_REGS];
    logic              irq_q;
    logic              clr_main;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [PTR_W-1:0] IDX = PTR_W'(k);
        if (k < NUM_STATUS) begin : g_status
            logic clr_k;
            assign clr_k = rd_pulse && (rd_addr == IDX);
            always_ff @(posedge clk) begin
                if (rst)
                    bank[k] <= '0;
                else
                    bank[k] <= (clr_k ? '0 : bank[k]) | evt_in[k*BYTE_W +: BYTE_W];
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    bank[k] <= '0;
                else if (wr_req.en && (wr_req.addr == IDX))
                    bank[k] <= wr_req.data;
            end
        end
        assign reg_bank[k*BYTE_W +: BYTE_W] = bank[k];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == PTR_W'(k))
                rd_data = bank[k];
        end
    end

    assign clr_main = rd_pulse && (rd_addr == '0);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (clr_main)
            irq_q <= 1'b0;
        else if (|(bank[0] & bank[IEN_IDX]))
            irq_q <= 1'b1;
    end

    assign irq_pull = irq_q;

endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
    import i2cs_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR   = 7'h10,
    parameter int unsigned NUM_REGS   = 29,
    parameter int unsigned NUM_STATUS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scl_in,
    input  logic                         sda_in,
    input  logic [NUM_STATUS*8-1:0]      evt_in,
    output logic                         sda_pull,
    output logic                         irq_pull,
    output logic [NUM_REGS*8-1:0]        reg_bank
);

    bus_evt_t          bus_evt;
    reg_wr_t           wr_req;
    logic              rd_pulse;
    logic [PTR_W-1:0]  rd_addr;
    logic [BYTE_W-1:0] rd_data;

    i2cs_bus_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (bus_evt)
    );

    i2cs_link #(
        .DEV_ADDR (DEV_ADDR)
    ) u_link (
        .clk      (clk),
        .rst      (rst),
        .evt      (bus_evt),
        .rd_data  (rd_data),
        .sda_oe   (sda_pull),
        .wr_req   (wr_req),
        .rd_pulse (rd_pulse),
        .rd_addr  (rd_addr)
    );

    i2cs_regfile #(
        .NUM_REGS   (NUM_REGS),
        .NUM_STATUS (NUM_STATUS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rd_pulse (rd_pulse),
        .rd_addr  (rd_addr),
        .evt_in   (evt_in),
        .rd_data  (rd_data),
        .irq_pull (irq_pull),
        .reg_bank (reg_bank)
    );

endmodule

// File: rtl/i2cs_regslave_chk.sv
module i2cs_regslave_chk
    import i2cs_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 29,
    parameter int unsigned NUM_STATUS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       irq_pull,
    input logic [NUM_REGS*8-1:0]      reg_bank,
    input logic [NUM_STATUS*8-1:0]    evt_in,
    input logic                       rd_pulse,
    input logic [PTR_W-1:0]           rd_addr,
    input reg_wr_t                    wr_req
);

    localparam int unsigned IEN = NUM_STATUS;

    // R8: the interrupt holds until status word 0 is read
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_pull && !(rd_pulse && rd_addr == '0)) |=> irq_pull);

    // R7: the interrupt only rises on an enabled status bit
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pull) |-> $past(|(reg_bank[7:0] & reg_bank[IEN*8 +: 8])));

    // R5: reading status word 1 with no new event leaves it empty
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && rd_addr == PTR_W'(1) && evt_in[15:8] == 8'h00) |=> reg_bank[15:8] == 8'h00);

    // R6: an event is never lost, even during a clear
    p_evt_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (|evt_in[7:0]) |=> ((reg_bank[7:0] & $past(evt_in[7:0])) == $past(evt_in[7:0])));

    // R10: a host write to status word 0 changes nothing
    p_ro_status_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req.en && wr_req.addr == '0 && !rd_pulse && evt_in[7:0] == 8'h00) |=> $stable(reg_bank[7:0]));

endmodule

bind i2cs_regslave i2cs_regslave_chk #(
    .NUM_REGS   (NUM_REGS),
    .NUM_STATUS (NUM_STATUS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_pull (irq_pull),
    .reg_bank (reg_bank),
    .evt_in   (evt_in),
    .rd_pulse (rd_pulse),
    .rd_addr  (rd_addr),
    .wr_req   (wr_req)
);

// File: tb/i2cs_regslave_tb.sv
module i2cs_regslave_tb;

    localparam int Q = 8;
    localparam int NREG = 29;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [15:0] evt_in = '0;
    logic sda_pull;
    logic irq_pull;
    logic [NREG*8-1:0] reg_bank;
    logic sda_line;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2cs_regslave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .evt_in   (evt_in),
        .sda_pull (sda_pull),
        .irq_pull (irq_pull),
        .reg_bank (reg_bank)
    );

    // addr, write data, expected readback
    localparam logic [23:0] VEC [6] = '{
        {8'h05, 8'hA5, 8'hA5},   // R2
        {8'h1C, 8'h3C, 8'h3C},   // R2 top register
        {8'h02, 8'h00, 8'h00},   // R2 enables
        {8'h1D, 8'h77, 8'h00},   // R10 reserved
        {8'h01, 8'hFF, 8'h00},   // R10 status read-only
        {8'h10, 8'h5A, 8'h5A}    // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] clr_mask, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        acked = ~sda_line;
        scl_m = 1'b0;
        evt_in[7:0] = clr_mask;
        @(negedge clk);
        evt_in[7:0] = 8'h00;
        repeat (Q - 1) @(negedge clk);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            hold();
            scl_m = 1'b1; hold();
            d = {d[6:0], sda_line};
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0;
        sda_m = 1'b1; hold();
    endtask

    task automatic wr_regs(input logic [7:0] ptr, input logic [23:0] d, input int n, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'h20, 8'h00, a); all_ack &= a;
        send_byte(ptr, 8'h00, a);   all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(d[8*i +: 8], 8'h00, a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic rd_regs_rs(input logic [7:0] ptr, input int n, output logic [23:0] r);
        logic a;
        logic [7:0] b;
        r = '0;
        bus_start();
        send_byte(8'h20, 8'h00, a);
        send_byte(ptr, 8'h00, a);
        bus_start();
        send_byte(8'h21, 8'h00, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            r[8*i +: 8] = b;
        end
        bus_stop();
    endtask

    task automatic rd_bare(input int n, input logic [7:0] clr_mask, output logic [23:0] r);
        logic a;
        logic [7:0] b;
        r = '0;
        bus_start();
        send_byte(8'h21, clr_mask, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            r[8*i +: 8] = b;
        end
        bus_stop();
    endtask

    task automatic pulse_evt(input logic [15:0] m);
        @(negedge clk); evt_in = m;
        @(negedge clk); evt_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        logic ok;
        logic a;
        logic [23:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R11 reset state
        check("R11 sda", {31'd0, sda_pull}, 32'd0);
        check("R11 irq", {31'd0, irq_pull}, 32'd0);
        check("R11 regs", {31'd0, reg_bank == '0}, 32'd1);

        // table walk: R2 and R10
        foreach (VEC[i]) begin
            wr_regs(VEC[i][23:16], {16'h0, VEC[i][15:8]}, 1, ok);
            check("R2 write ack", {31'd0, ok}, 32'd1);
            rd_regs_rs(VEC[i][23:16], 1, r);
            check("R2/R10 readback", {24'd0, r[7:0]}, {24'd0, VEC[i][7:0]});
        end

        // R1 foreign address is not acknowledged and writes nothing
        bus_start();
        send_byte(8'h22, 8'h00, a);
        check("R1 foreign nack", {31'd0, a}, 32'd0);
        send_byte(8'h06, 8'h00, a);
        send_byte(8'hEE, 8'h00, a);
        bus_stop();
        check("R1 no write", {24'd0, reg_bank[8*6 +: 8]}, 32'h00);

        // R2 burst write with auto increment
        wr_regs(8'h07, 24'h332211, 3, ok);
        check("R2 burst ack", {31'd0, ok}, 32'd1);
        check("R2 burst regs", {8'd0, reg_bank[8*9 +: 8], reg_bank[8*8 +: 8], reg_bank[8*7 +: 8]}, 32'h00332211);

        // R4 burst read with master acks, then NACK releases SDA
        rd_regs_rs(8'h07, 3, r);
        check("R4 burst read", {8'd0, r}, 32'h00332211);
        check("R4 sda released", {31'd0, sda_pull}, 32'd0);

        // R3 and R5: bare read starts at status 0 regardless of pointer
        pulse_evt(16'h2004);
        wr_regs(8'h07, 24'h0, 0, ok);
        rd_bare(2, 8'h00, r);
        check("R3 bare read origin", {16'd0, r[15:0]}, 32'h00002004);
        rd_bare(2, 8'h00, r);
        check("R5 cleared on read", {16'd0, r[15:0]}, 32'h0);

        // R7 interrupt from enabled flags only
        wr_regs(8'h02, 24'h000009, 1, ok);
        pulse_evt(16'h0002);
        repeat (3) @(negedge clk);
        check("R7 masked flag no irq", {31'd0, irq_pull}, 32'd0);
        pulse_evt(16'h0008);
        repeat (3) @(negedge clk);
        check("R7 enabled flag irq", {31'd0, irq_pull}, 32'd1);

        // R8 hold through a status-1 read and repeated events
        rd_regs_rs(8'h01, 1, r);
        pulse_evt(16'h0008);
        repeat (3) @(negedge clk);
        check("R8 irq held", {31'd0, irq_pull}, 32'd1);
        rd_bare(1, 8'h00, r);
        check("R8 status value", {24'd0, r[7:0]}, 32'h0A);
        repeat (3) @(negedge clk);
        check("R8 irq released", {31'd0, irq_pull}, 32'd0);

        // R6 event coinciding with the clear survives it
        rd_bare(1, 8'h40, r);
        check("R6 first read", {24'd0, r[7:0]}, 32'h00);
        rd_bare(1, 8'h00, r);
        check("R6 event kept", {24'd0, r[7:0]}, 32'h40);

        // R9 STOP mid-byte discards the partial byte
        bus_start();
        send_byte(8'h20, 8'h00, a);
        send_byte(8'h0A, 8'h00, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        hold();
        bus_stop();
        check("R9 partial byte", {24'd0, reg_bank[8*10 +: 8]}, 32'h00);
        wr_regs(8'h0B, 24'h000066, 1, ok);
        check("R9 recovers", {23'd0, ok, reg_bank[8*11 +: 8]}, 32'h166);

        // R9 stop edge in the START's own high period is ignored
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        sda_m = 1'b1; hold();
        scl_m = 1'b0; hold();
        send_byte(8'h20, 8'h00, a);
        check("R9 early stop ignored", {31'd0, a}, 32'd1);
        send_byte(8'h0C, 8'h00, a);
        send_byte(8'h99, 8'h00, a);
        bus_stop();
        check("R9 write after early stop", {24'd0, reg_bank[8*12 +: 8]}, 32'h99);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule